// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block sits behind the write port of a parallel NOR flash model. It watches 16-bit host writes (address and data) and follows the unlock-prefixed command sequences. It keeps the device's steady mode: array read, identifier read, query-table read or fast program. It tells the read multiplexer which source to return. When a sequence completes it issues an operation request (program, sector erase, chip erase, erase suspend) carrying the full target offset and data. A separate embedded-operation engine accepts these requests and reports back through two busy inputs.

Host writes arrive on a valid/ready channel. `wr_ready` is low while an issued operation has not yet been taken. Operation requests leave on a second valid/ready channel. A request stays valid with stable fields until `op_ready` is seen high at a clock edge. Command matching uses bits [7:0] of the data and only the low 11 bits of the word address (byte address shifted right by one). Program and erase targets keep the whole byte offset.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, mode is 0 (array), rd_src is 0 (array), op_valid is 0 and wr_ready is 1.
- R2: The writes AA at word 0x555, 55 at word 0x2AA, 90 at word 0x555 enter identifier mode: mode 1, rd_src 1. A third-cycle value other than 90, A0, 20, 80 or F0 leaves mode unchanged.
- R3: Command addresses compare only word-address bits [10:0]. Upper address bits are ignored. A single flipped bit in [10:0] makes the cycle fail.
- R4: After unlock and A0, the next write issues op_kind 0 (program) with its full byte address and data. The request and its fields hold until op_ready is taken. wr_ready is 0 while op_valid is 1.
- R5: Unlock and 20 enter fast-program mode (mode 3, rd_src 0). There, A0 then one write issues a program request. 90 then 00 returns to mode 0. 90 then any other value stays in mode 3.
- R6: Unlock, 80, AA at 0x555, 55 at 0x2AA, then 30 at any address issues op_kind 1 (sector erase) with that full address. If the last write is instead 10 at 0x555, op_kind 2 (chip erase) is issued.
- R7: The value 98 at word 0x55 enters query mode (mode 2, rd_src 2) from mode 0 or 1. F0 then returns to mode 1 if query mode was entered from mode 1, and to mode 0 otherwise.
- R8: F0 at any address clears any partial sequence. It returns mode 1 to mode 0 when the engine is idle.
- R9: A write that does not fit the expected cycle drops the partial sequence and keeps the steady mode. No request is issued.
- R10: While eng_chip_busy is 1, every write is ignored, F0 included.
- R11: While eng_sect_busy is 1, only B0 is accepted and it issues op_kind 3 (suspend). F0 and other writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_valid | input | 1 | host write present |
| wr_ready | output | 1 | write accepted this cycle |
| wr_addr | input | AW | byte address of the write |
| wr_data | input | 16 | write data |
| eng_chip_busy | input | 1 | chip erase in progress |
| eng_sect_busy | input | 1 | sector erase in progress |
| op_valid | output | 1 | operation request pending |
| op_ready | input | 1 | engine takes the request |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 chip erase, 3 suspend |
| op_addr | output | AW | full byte target address |
| op_data | output | 16 | program data |
| mode | output | 2 | 0 array, 1 identifier, 2 query, 3 fast program |
| rd_src | output | 2 | read mux select: 0 array, 1 identifier, 2 query |

## Verification
A corrupted sequence step is invisible until a later write. It shows up as a wrong `mode` or a missing or extra request one cycle after the write that should have completed the sequence. So each third-cycle value is followed by a probe write. A lost query return flag shows only on the F0 that follows, as mode 0 where 1 is due. Busy-gating faults show as a mode change or a request on the cycle after an ignored write.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [1:0] {MD_ARRAY = 2'd0, MD_IDENT = 2'd1, MD_QUERY = 2'd2, MD_FAST = 2'd3} md_t;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2, OP_SUSP = 2'd3} op_t;
  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E1, SQ_E2, SQ_E3, SQ_FPROG, SQ_FEXIT
  } sq_t;

  localparam logic [7:0] K_UNL1  = 8'hAA;
  localparam logic [7:0] K_UNL2  = 8'h55;
  localparam logic [7:0] K_IDENT = 8'h90;
  localparam logic [7:0] K_PROG  = 8'hA0;
  localparam logic [7:0] K_FAST  = 8'h20;
  localparam logic [7:0] K_ESET  = 8'h80;
  localparam logic [7:0] K_SECT  = 8'h30;
  localparam logic [7:0] K_CHIP  = 8'h10;
  localparam logic [7:0] K_QUERY = 8'h98;
  localparam logic [7:0] K_RESET = 8'hF0;
  localparam logic [7:0] K_SUSP  = 8'hB0;
  localparam logic [7:0] K_FOUT  = 8'h00;
endpackage

// File: rtl/nor_addr_match.sv
module nor_addr_match #(
  parameter int AW       = 20,
  parameter int CMD_BITS = 11
) (
  input  logic [AW-1:0] byte_addr,
  output logic          hit_555,
  output logic          hit_2aa,
  output logic          hit_55
);
  localparam logic [CMD_BITS-1:0] A555 = CMD_BITS'('h555);
  localparam logic [CMD_BITS-1:0] A2AA = CMD_BITS'('h2AA);
  localparam logic [CMD_BITS-1:0] A55  = CMD_BITS'('h055);

  logic [CMD_BITS-1:0] word_lo;
  assign word_lo = byte_addr[CMD_BITS:1];
  assign hit_555 = (word_lo == A555);
  assign hit_2aa = (word_lo == A2AA);
  assign hit_55  = (word_lo == A55);
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] cmd,
  input  logic       hit_555,
  input  logic       hit_2aa,
  input  logic       hit_55,
  input  logic       chip_busy,
  input  logic       sect_busy,
  output md_t        mode,
  output logic       issue,
  output op_t        issue_kind
);
  sq_t  sq, sq_n;
  md_t  mode_n;
  logic from_ident, from_ident_n;

  always_comb begin
    sq_n         = sq;
    mode_n       = mode;
    from_ident_n = from_ident;
    issue        = 1'b0;
    issue_kind   = OP_PROG;
    if (fire && !chip_busy) begin
      if (sect_busy) begin
        if (cmd == K_SUSP) begin
          issue      = 1'b1;
          issue_kind = OP_SUSP;
        end
      end else if (cmd == K_RESET) begin
        sq_n         = SQ_IDLE;
        mode_n       = (mode == MD_QUERY && from_ident) ? MD_IDENT : MD_ARRAY;
        from_ident_n = 1'b0;
      end else begin
        sq_n = SQ_IDLE;
        case (mode)
          MD_QUERY: ;
          MD_FAST: begin
            case (sq)
              SQ_IDLE: begin
                if (cmd == K_PROG) sq_n = SQ_FPROG;
                else if (cmd == K_IDENT) sq_n = SQ_FEXIT;
              end
              SQ_FPROG: issue = 1'b1;
              SQ_FEXIT: if (cmd == K_FOUT) mode_n = MD_ARRAY;
              default: ;
            endcase
          end
          default: begin
            case (sq)
              SQ_IDLE: begin
                if (cmd == K_UNL1 && hit_555) sq_n = SQ_U1;
                else if (cmd == K_QUERY && hit_55) begin
                  mode_n       = MD_QUERY;
                  from_ident_n = (mode == MD_IDENT);
                end
              end
              SQ_U1: if (cmd == K_UNL2 && hit_2aa) sq_n = SQ_U2;
              SQ_U2: begin
                if (hit_555) begin
                  case (cmd)
                    K_IDENT: mode_n = MD_IDENT;
                    K_PROG:  sq_n   = SQ_PROG;
                    K_FAST:  mode_n = MD_FAST;
                    K_ESET:  sq_n   = SQ_E1;
                    default: ;
                  endcase
                end
              end
              SQ_PROG: issue = 1'b1;
              SQ_E1: if (cmd == K_UNL1 && hit_555) sq_n = SQ_E2;
              SQ_E2: if (cmd == K_UNL2 && hit_2aa) sq_n = SQ_E3;
              SQ_E3: begin
                if (cmd == K_SECT) begin
                  issue      = 1'b1;
                  issue_kind = OP_SECT;
                end else if (cmd == K_CHIP && hit_555) begin
                  issue      = 1'b1;
                  issue_kind = OP_CHIP;
                end
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq         <= SQ_IDLE;
      mode       <= MD_ARRAY;
      from_ident <= 1'b0;
    end else begin
      sq         <= sq_n;
      mode       <= mode_n;
      from_ident <= from_ident_n;
    end
  end
endmodule

// File: rtl/nor_op_stage.sv
module nor_op_stage
  import nor_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  op_t           issue_kind,
  input  logic [AW-1:0] issue_addr,
  input  logic [DW-1:0] issue_data,
  input  logic          op_ready,
  output logic          op_valid,
  output op_t           op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_kind  <= OP_PROG;
      op_addr  <= '0;
      op_data  <= '0;
    end else if (issue) begin
      op_valid <= 1'b1;
      op_kind  <= issue_kind;
      op_addr  <= issue_addr;
      op_data  <= issue_data;
    end else if (op_ready) begin
      op_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int AW       = 20,
  parameter int CMD_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          eng_chip_busy,
  input  logic          eng_sect_busy,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [1:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [15:0]   op_data,
  output logic [1:0]    mode,
  output logic [1:0]    rd_src
);
  localparam int DW = 16;

  logic fire, hit_555, hit_2aa, hit_55, issue;
  op_t  issue_kind, kind_q;
  md_t  md;

  assign wr_ready = !op_valid;
  assign fire     = wr_valid && wr_ready;

  nor_addr_match #(.AW(AW), .CMD_BITS(CMD_BITS)) u_match (
    .byte_addr(wr_addr), .hit_555(hit_555), .hit_2aa(hit_2aa), .hit_55(hit_55)
  );

  nor_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cmd(wr_data[7:0]),
    .hit_555(hit_555), .hit_2aa(hit_2aa), .hit_55(hit_55),
    .chip_busy(eng_chip_busy), .sect_busy(eng_sect_busy),
    .mode(md), .issue(issue), .issue_kind(issue_kind)
  );

  nor_op_stage #(.AW(AW), .DW(DW)) u_ops (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_kind(issue_kind),
    .issue_addr(wr_addr), .issue_data(wr_data), .op_ready(op_ready),
    .op_valid(op_valid), .op_kind(kind_q), .op_addr(op_addr), .op_data(op_data)
  );

  assign op_kind = kind_q;
  assign mode    = md;

  always_comb begin
    case (md)
      MD_IDENT: rd_src = 2'd1;
      MD_QUERY: rd_src = 2'd2;
      default:  rd_src = 2'd0;
    endcase
  end
endmodule

// File: rtl/nor_cmd_checker.sv
module nor_cmd_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          eng_chip_busy,
  input logic          eng_sect_busy,
  input logic          op_valid,
  input logic          op_ready,
  input logic [1:0]    op_kind,
  input logic [AW-1:0] op_addr,
  input logic [15:0]   op_data,
  input logic [1:0]    mode,
  input logic [1:0]    rd_src
);
  a_r1_leave_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == 2'd0 && !op_valid));

  a_r4_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(op_addr) && $stable(op_data)));

  a_r4_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !wr_ready);

  a_r7_query_src: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (rd_src == 2'd2));

  a_r10_chip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    eng_chip_busy |=> ($stable(mode) && !$rose(op_valid)));

  a_r11_sect_mode: assert property (@(posedge clk) disable iff (!rst_n)
    eng_sect_busy |=> $stable(mode));

  a_r11_sect_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_sect_busy && !eng_chip_busy && $rose(op_valid)) |-> (op_kind == 2'd3));
endmodule

bind nor_cmd_decoder nor_cmd_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .eng_chip_busy(eng_chip_busy), .eng_sect_busy(eng_sect_busy),
  .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
  .op_addr(op_addr), .op_data(op_data), .mode(mode), .rd_src(rd_src)
);

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;
  localparam int AW = 20;
  localparam logic [AW-1:0] B555 = 20'h00AAA;
  localparam logic [AW-1:0] B2AA = 20'h00554;
  localparam logic [AW-1:0] B55  = 20'h000AA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic chip_busy = 1'b0, sect_busy = 1'b0;
  logic op_valid, op_ready = 1'b0;
  logic [1:0] op_kind, mode, rd_src;
  logic [AW-1:0] op_addr;
  logic [15:0] op_data;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nor_cmd_decoder #(.AW(AW)) i_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .eng_chip_busy(chip_busy),
    .eng_sect_busy(sect_busy), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .mode(mode), .rd_src(rd_src)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(B555, 16'h00AA);
    wr(B2AA, 16'h0055);
  endtask

  task automatic take_op();
    @(negedge clk);
    op_ready = 1'b1;
    @(negedge clk);
    op_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 rd_src", rd_src, 0);
    chk("R1 op_valid", op_valid, 0);
    chk("R1 wr_ready", wr_ready, 1);

    // sweep of every third-cycle value (R2, R4, R5, R8, R9)
    for (int d = 0; d < 256; d++) begin
      int exp_mode;
      do_reset();
      unlock();
      wr(B555, 16'(d));
      exp_mode = (d == 'h90) ? 1 : (d == 'h20) ? 3 : 0;
      if (d == 'h90) chk("R2 ident mode", mode, exp_mode);
      else if (d == 'h20) chk("R5 fast mode", mode, exp_mode);
      else if (d == 'hF0) chk("R8 reset mode", mode, exp_mode);
      else chk("R9 third cycle", mode, exp_mode);
      if (d == 'h90) chk("R2 rd_src", rd_src, 1);
      wr(20'h00200, 16'h1234);
      if (d == 'hA0) begin
        chk("R4 op_valid", op_valid, 1);
        chk("R4 kind", op_kind, 0);
        chk("R4 addr", op_addr, 'h200);
        chk("R4 data", op_data, 'h1234);
        chk("R4 wr_ready low", wr_ready, 0);
        repeat (3) @(negedge clk);
        chk("R4 held", op_valid, 1);
        chk("R4 held addr", op_addr, 'h200);
        take_op();
        chk("R4 released", op_valid, 0);
      end else begin
        chk("R9 no request", op_valid, 0);
      end
    end

    // R3 upper address bits ignored
    for (int hi = 0; hi < 16; hi++) begin
      logic [AW-1:0] up;
      up = AW'(hi) << 12;
      do_reset();
      wr(up | B555, 16'h00AA);
      wr(up | B2AA, 16'h0055);
      wr(up | B555, 16'h0090);
      chk("R3 alias", mode, 1);
    end
    // R3 any flipped low bit breaks the match
    for (int b = 0; b < 11; b++) begin
      do_reset();
      wr(B555 ^ (AW'(1) << (b + 1)), 16'h00AA);
      wr(B2AA, 16'h0055);
      wr(B555, 16'h0090);
      chk("R3 flipped bit", mode, 0);
    end

    // R6 sector erase
    do_reset();
    unlock(); wr(B555, 16'h0080); unlock();
    wr(20'h30000, 16'h0030);
    chk("R6 sect valid", op_valid, 1);
    chk("R6 sect kind", op_kind, 1);
    chk("R6 sect addr", op_addr, 'h30000);
    take_op();
    // R6 chip erase
    unlock(); wr(B555, 16'h0080); unlock();
    wr(B555, 16'h0010);
    chk("R6 chip valid", op_valid, 1);
    chk("R6 chip kind", op_kind, 2);
    take_op();

    // R7 query mode from array and from identifier
    do_reset();
    wr(B55, 16'h0098);
    chk("R7 query mode", mode, 2);
    chk("R7 query src", rd_src, 2);
    wr(20'h00010, 16'h00F0);
    chk("R7 back to array", mode, 0);
    unlock(); wr(B555, 16'h0090);
    wr(B55, 16'h0098);
    chk("R7 query from ident", mode, 2);
    wr(20'h00010, 16'h00F0);
    chk("R7 first reset", mode, 1);
    wr(20'h00010, 16'h00F0);
    chk("R7 second reset", mode, 0);

    // R5 fast program mode
    do_reset();
    unlock(); wr(B555, 16'h0020);
    chk("R5 rd_src", rd_src, 0);
    wr(20'h00000, 16'h00A0);
    wr(20'h4567A, 16'hBEEF);
    chk("R5 prog valid", op_valid, 1);
    chk("R5 prog addr", op_addr, 'h4567A);
    chk("R5 prog data", op_data, 'hBEEF);
    take_op();
    wr(20'h00000, 16'h0090);
    wr(20'h00000, 16'h0055);
    chk("R5 bad exit", mode, 3);
    wr(20'h00000, 16'h0090);
    wr(20'h00000, 16'h0000);
    chk("R5 exit", mode, 0);

    // R8 reset mid-sequence
    do_reset();
    unlock();
    wr(20'h12345, 16'h00F0);
    wr(B555, 16'h0090);
    chk("R8 partial cleared", mode, 0);

    // R9 abort keeps identifier mode
    unlock(); wr(B555, 16'h0090);
    wr(B555, 16'h00AA);
    wr(B555, 16'h0077);
    chk("R9 stays ident", mode, 1);

    // R10 chip erase busy
    chip_busy = 1'b1;
    wr(20'h00000, 16'h00F0);
    chk("R10 reset ignored", mode, 1);
    wr(20'h00000, 16'h00B0);
    chk("R10 suspend ignored", op_valid, 0);
    chip_busy = 1'b0;

    // R11 sector erase busy
    sect_busy = 1'b1;
    wr(20'h00000, 16'h00F0);
    chk("R11 reset ignored", mode, 1);
    wr(20'h00000, 16'h00B0);
    chk("R11 suspend valid", op_valid, 1);
    chk("R11 suspend kind", op_kind, 3);
    take_op();
    sect_busy = 1'b0;
    wr(20'h00000, 16'h00F0);
    chk("R8 ident reset", mode, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule